// File: doc/BRIEF.md
# Single-Accumulator Processor Core with Interrupt Cycle

This block is a small processor core that works on 16-bit words. It holds one accumulator. Each instruction word splits into an operation code in the top four bits and a 12-bit memory address in the remaining bits. The core drives one memory port and performs every instruction as a fixed series of register-transfer steps. Three steps fetch the instruction. Three steps carry it out. After each instruction the core checks whether an interrupt should be taken, and if so it runs three more steps that save the program counter.

The memory port is a plain single-port interface. The address comes straight from the core's address register. Read data must show the addressed word within the same cycle. A write takes effect at the clock edge on which the write enable is high.

Interrupt handling is deliberately minimal. After reset the interrupt enable is set. Taking an interrupt clears it, and only a new reset sets it again. The handler's return address is left in memory word 0x000, and execution resumes at word 0x001.

Top module: `acc_core`

## Requirements
- R1: While reset is low, pc_out reads 0x300, acc_out reads 0, int_en reads 1, halted reads 0 and mem_we reads 0.
- R2: The operation code is instruction bits 15:12 and the operand address is bits 11:0. Code 0x1 loads the addressed word into the accumulator.
- R3: Code 0x2 writes the accumulator into the addressed word. During that write cycle mem_we is 1, mem_addr equals the operand address and mem_wdata equals the accumulator.
- R4: Code 0x5 adds the addressed word to the accumulator modulo 2^16, with no flags.
- R5: Every instruction other than halt takes exactly six cycles, three to fetch and three to execute, and the fetch raises the program counter by one. The program 1940, 5941, 2941 at 0x300, with 0003 at 0x940 and 0002 at 0x941, leaves 0005 in word 0x941 and pc_out at 0x303 eighteen cycles after reset is released.
- R6: Code 0x0 stops the core. Once halted is 1 it stays 1, pc_out stays frozen one past the halt word, and no further write occurs.
- R7: Every other code is a no-op. It leaves the accumulator and memory untouched and still takes six cycles.
- R8: When irq is 1 and int_en is 1 at the end of an execute, the core runs a three-cycle interrupt sequence. The second cycle ends with pc_out at 0x001 and int_en at 0. In the third cycle the core writes the zero-extended return address to word 0x000. Fetching then resumes at 0x001.
- R9: When int_en is 0, or when irq is 0, the core goes directly from execute to the next fetch and never writes word 0x000. Only reset sets int_en again.
- R10: mem_we is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 1 | Level-sensitive interrupt request |
| mem_rdata | input | 16 | Word at mem_addr, valid in the same cycle |
| mem_addr | output | 12 | Memory address, taken from the address register |
| mem_wdata | output | 16 | Write data, taken from the buffer register |
| mem_we | output | 1 | Write strobe for one cycle |
| halted | output | 1 | High once a halt instruction has executed |
| pc_out | output | 12 | Program counter |
| acc_out | output | 16 | Accumulator |
| int_en | output | 1 | Global interrupt enable |

## Verification
The assertions take for granted that mem_rdata returns the addressed word with no wait state. They also assume irq is held steady long enough to be seen at the end of an execute step, because no request is latched. The bench meets both conditions with a combinational-read memory model and with irq held at a fixed level for the whole of each scenario. Each program loaded into memory ends in a halt word, so the core never runs into empty memory.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OPC_HALT  = 4'h0;
  localparam logic [OP_W-1:0] OPC_LOAD  = 4'h1;
  localparam logic [OP_W-1:0] OPC_STORE = 4'h2;
  localparam logic [OP_W-1:0] OPC_ADD   = 4'h5;

  typedef enum logic [3:0] {
    ST_F1, ST_F2, ST_F3,
    ST_E1, ST_E2, ST_E3,
    ST_I1, ST_I2, ST_I3,
    ST_HALT
  } step_e;

  // register-transfer enables for one step
  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mar_from_save;
    logic mbr_from_mem;
    logic mbr_from_ac;
    logic mbr_from_pc;
    logic ir_from_mbr;
    logic pc_inc;
    logic pc_to_handler;
    logic ac_from_mbr;
    logic ac_from_sum;
    logic ie_clear;
  } xfer_t;

  function automatic logic uses_operand(input logic [OP_W-1:0] op);
    return (op == OPC_LOAD) || (op == OPC_STORE) || (op == OPC_ADD);
  endfunction
endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq,
  input  logic            int_en,
  input  logic [OP_W-1:0] opcode,
  output xfer_t           xf,
  output logic            mem_write,
  output logic            save_write,
  output logic            halted
);
  step_e state, nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_F1;
    else        state <= nxt;
  end

  always_comb begin
    xf         = '0;
    mem_write  = 1'b0;
    save_write = 1'b0;
    nxt        = state;
    case (state)
      ST_F1: begin xf.mar_from_pc = 1'b1; nxt = ST_F2; end
      ST_F2: begin xf.mbr_from_mem = 1'b1; xf.pc_inc = 1'b1; nxt = ST_F3; end
      ST_F3: begin xf.ir_from_mbr = 1'b1; nxt = ST_E1; end
      ST_E1: begin
        if (opcode == OPC_HALT) nxt = ST_HALT;
        else begin
          xf.mar_from_ir = uses_operand(opcode);
          nxt = ST_E2;
        end
      end
      ST_E2: begin
        xf.mbr_from_mem = (opcode == OPC_LOAD) || (opcode == OPC_ADD);
        xf.mbr_from_ac  = (opcode == OPC_STORE);
        nxt = ST_E3;
      end
      ST_E3: begin
        xf.ac_from_mbr = (opcode == OPC_LOAD);
        xf.ac_from_sum = (opcode == OPC_ADD);
        mem_write      = (opcode == OPC_STORE);
        nxt = (irq && int_en) ? ST_I1 : ST_F1;
      end
      ST_I1: begin xf.mbr_from_pc = 1'b1; nxt = ST_I2; end
      ST_I2: begin
        xf.mar_from_save = 1'b1;
        xf.pc_to_handler = 1'b1;
        xf.ie_clear      = 1'b1;
        nxt = ST_I3;
      end
      ST_I3: begin mem_write = 1'b1; save_write = 1'b1; nxt = ST_F1; end
      ST_HALT: nxt = ST_HALT;
      default: nxt = ST_F1;
    endcase
  end

  assign halted = (state == ST_HALT);
endmodule

// File: rtl/acc_regs.sv
module acc_regs
  import acc_pkg::*;
#(
  parameter int                ADDR_W       = 12,
  parameter logic [ADDR_W-1:0] RESET_PC     = 'h300,
  parameter logic [ADDR_W-1:0] SAVE_ADDR    = 'h000,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 'h001,
  localparam int               DATA_W       = ADDR_W + OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xfer_t             xf,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mbr,
  output logic [DATA_W-1:0] ac,
  output logic              ie
);
  logic [DATA_W-1:0] ir;

  function automatic logic [DATA_W-1:0] wrap_add(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    logic [DATA_W:0] full;
    full = {1'b0, a} + {1'b0, b};
    return full[DATA_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= RESET_PC;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      ac  <= '0;
      ie  <= 1'b1;
    end else begin
      if (xf.mar_from_pc)        mar <= pc;
      else if (xf.mar_from_ir)   mar <= ir[ADDR_W-1:0];
      else if (xf.mar_from_save) mar <= SAVE_ADDR;

      if (xf.mbr_from_mem)      mbr <= mem_rdata;
      else if (xf.mbr_from_ac)  mbr <= ac;
      else if (xf.mbr_from_pc)  mbr <= {{OP_W{1'b0}}, pc};

      if (xf.ir_from_mbr) ir <= mbr;

      if (xf.pc_inc)             pc <= pc + 1'b1;
      else if (xf.pc_to_handler) pc <= HANDLER_ADDR;

      if (xf.ac_from_mbr)      ac <= mbr;
      else if (xf.ac_from_sum) ac <= wrap_add(ac, mbr);

      if (xf.ie_clear) ie <= 1'b0;
    end
  end

  assign opcode = ir[DATA_W-1 -: OP_W];
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int                ADDR_W       = 12,
  parameter logic [ADDR_W-1:0] RESET_PC     = 'h300,
  parameter logic [ADDR_W-1:0] SAVE_ADDR    = 'h000,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 'h001,
  localparam int               DATA_W       = ADDR_W + OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              halted,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] acc_out,
  output logic              int_en
);
  xfer_t             xf;
  logic [OP_W-1:0]   opcode;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mbr;
  logic              mem_write;
  logic              save_write;

  // named events for the bound checker
  logic ev_fetch_inc;
  logic ev_store_wr;
  logic ev_save_wr;

  acc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq        (irq),
    .int_en     (int_en),
    .opcode     (opcode),
    .xf         (xf),
    .mem_write  (mem_write),
    .save_write (save_write),
    .halted     (halted)
  );

  acc_regs #(
    .ADDR_W       (ADDR_W),
    .RESET_PC     (RESET_PC),
    .SAVE_ADDR    (SAVE_ADDR),
    .HANDLER_ADDR (HANDLER_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .xf        (xf),
    .mem_rdata (mem_rdata),
    .opcode    (opcode),
    .pc        (pc_out),
    .mar       (mar),
    .mbr       (mbr),
    .ac        (acc_out),
    .ie        (int_en)
  );

  assign mem_addr     = mar;
  assign mem_wdata    = mbr;
  assign mem_we       = mem_write;
  assign ev_fetch_inc = xf.pc_inc;
  assign ev_store_wr  = mem_write & ~save_write;
  assign ev_save_wr   = save_write;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int                ADDR_W       = 12,
  parameter logic [ADDR_W-1:0] SAVE_ADDR    = 'h000,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 'h001,
  localparam int               DATA_W       = ADDR_W + 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_we,
  input logic              halted,
  input logic [ADDR_W-1:0] pc_out,
  input logic [DATA_W-1:0] acc_out,
  input logic              int_en,
  input logic              ev_fetch_inc,
  input logic              ev_store_wr,
  input logic              ev_save_wr
);
  // R10
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R6
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc_out) && !mem_we));

  // R5
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch_inc |=> (pc_out == ADDR_W'($past(pc_out) + 1'b1)));

  // R8
  irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_en) |-> (pc_out == HANDLER_ADDR && mem_addr == SAVE_ADDR));

  // R8
  save_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_save_wr |-> (mem_we && mem_addr == SAVE_ADDR && !int_en));

  // R9
  ie_no_reenable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(int_en));

  // R3
  store_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_store_wr |-> (mem_we && mem_wdata == acc_out));
endmodule

bind acc_core acc_core_chk #(
  .ADDR_W       (ADDR_W),
  .SAVE_ADDR    (SAVE_ADDR),
  .HANDLER_ADDR (HANDLER_ADDR)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .mem_we       (mem_we),
  .halted       (halted),
  .pc_out       (pc_out),
  .acc_out      (acc_out),
  .int_en       (int_en),
  .ev_fetch_inc (ev_fetch_inc),
  .ev_store_wr  (ev_store_wr),
  .ev_save_wr   (ev_save_wr)
);

// File: tb/test_acc_core.sv
module test_acc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic [15:0] mem_rdata;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic        halted;
  logic [11:0] pc_out;
  logic [15:0] acc_out;
  logic        int_en;

  logic [15:0] mem [0:4095];
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  acc_core i_acc_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .halted    (halted),
    .pc_out    (pc_out),
    .acc_out   (acc_out),
    .int_en    (int_en)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_sum(input logic [15:0] a, input logic [15:0] b);
    logic [31:0] s;
    s = 32'(a) + 32'(b);
    return s[15:0];
  endfunction

  // hold reset, clear memory; caller fills words, then calls release_rst
  task automatic hold_rst();
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  task automatic release_rst();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_halt(input string req);
    int n = 0;
    while (!halted && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(req, {31'd0, halted}, 32'd1);
  endtask

  task automatic t_reset_state();
    hold_rst();
    irq = 1'b0;
    @(negedge clk);
    chk("R1 pc", {20'd0, pc_out}, 32'h300);
    chk("R1 acc", {16'd0, acc_out}, 32'd0);
    chk("R1 int_en", {31'd0, int_en}, 32'd1);
    chk("R1 halted", {31'd0, halted}, 32'd0);
    chk("R1 mem_we", {31'd0, mem_we}, 32'd0);
  endtask

  task automatic t_sample_program();
    hold_rst();
    irq = 1'b0;
    mem[12'h300] = 16'h1940; mem[12'h301] = 16'h5941;
    mem[12'h302] = 16'h2941; mem[12'h303] = 16'h0000;
    mem[12'h940] = 16'h0003; mem[12'h941] = 16'h0002;
    mem[12'h000] = 16'hBEEF;
    release_rst();
    edges(6);
    chk("R2 load acc", {16'd0, acc_out}, 32'h3);
    chk("R5 pc after one", {20'd0, pc_out}, 32'h301);
    edges(6);
    chk("R4 add acc", {16'd0, acc_out}, {16'd0, ref_sum(16'h3, 16'h2)});
    edges(5);
    chk("R3 we", {31'd0, mem_we}, 32'd1);
    chk("R3 addr", {20'd0, mem_addr}, 32'h941);
    chk("R3 wdata", {16'd0, mem_wdata}, 32'h5);
    edges(1);
    chk("R5 word 941", {16'd0, mem[12'h941]}, 32'h5);
    chk("R5 pc 303", {20'd0, pc_out}, 32'h303);
    wait_halt("R6 halt reached");
    chk("R9 word 0 untouched", {16'd0, mem[12'h000]}, 32'hBEEF);
  endtask

  task automatic t_halt_hold();
    // continues from the halted sample program
    edges(10);
    chk("R6 halted stays", {31'd0, halted}, 32'd1);
    chk("R6 pc frozen", {20'd0, pc_out}, 32'h304);
    chk("R6 no write", {16'd0, mem[12'h941]}, 32'h5);
    chk("R6 we low", {31'd0, mem_we}, 32'd0);
  endtask

  task automatic t_add_wrap();
    hold_rst();
    irq = 1'b0;
    mem[12'h300] = 16'h1940; mem[12'h301] = 16'h5941;
    mem[12'h302] = 16'h2942; mem[12'h303] = 16'h5943;
    mem[12'h304] = 16'h0000;
    mem[12'h940] = 16'hFFFF; mem[12'h941] = 16'h0002; mem[12'h943] = 16'hFFFF;
    release_rst();
    wait_halt("R4 halt reached");
    chk("R4 wrap store", {16'd0, mem[12'h942]}, {16'd0, ref_sum(16'hFFFF, 16'h0002)});
    chk("R4 second wrap acc", {16'd0, acc_out},
        {16'd0, ref_sum(ref_sum(16'hFFFF, 16'h0002), 16'hFFFF)});
  endtask

  task automatic t_noop();
    hold_rst();
    irq = 1'b0;
    mem[12'h300] = 16'h1940; mem[12'h301] = 16'h7941;
    mem[12'h302] = 16'h2942; mem[12'h303] = 16'h0000;
    mem[12'h940] = 16'h0003; mem[12'h941] = 16'h0002;
    release_rst();
    edges(12);
    chk("R7 acc kept", {16'd0, acc_out}, 32'h3);
    chk("R7 six cycles", {20'd0, pc_out}, 32'h302);
    wait_halt("R7 halt reached");
    chk("R7 word 941 kept", {16'd0, mem[12'h941]}, 32'h2);
    chk("R7 store after", {16'd0, mem[12'h942]}, 32'h3);
  endtask

  task automatic t_irq_taken();
    hold_rst();
    irq = 1'b1;
    mem[12'h300] = 16'h1940; mem[12'h301] = 16'h0000;
    mem[12'h001] = 16'h1941; mem[12'h002] = 16'h0000;
    mem[12'h940] = 16'h0003; mem[12'h941] = 16'h0002;
    mem[12'h000] = 16'hBEEF;
    release_rst();
    edges(6);
    chk("R8 acc before irq", {16'd0, acc_out}, 32'h3);
    edges(2);
    chk("R8 pc handler", {20'd0, pc_out}, 32'h001);
    chk("R8 ie cleared", {31'd0, int_en}, 32'd0);
    chk("R8 save we", {31'd0, mem_we}, 32'd1);
    chk("R8 save addr", {20'd0, mem_addr}, 32'h000);
    chk("R8 save data", {16'd0, mem_wdata}, 32'h301);
    wait_halt("R8 halt in handler");
    chk("R8 handler ran", {16'd0, acc_out}, 32'h2);
    chk("R9 no second save", {16'd0, mem[12'h000]}, 32'h301);
    chk("R9 pc after handler", {20'd0, pc_out}, 32'h003);
    chk("R9 ie stays low", {31'd0, int_en}, 32'd0);
    irq = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset_state();
    t_sample_program();
    t_halt_hold();
    t_add_wrap();
    t_noop();
    t_irq_taken();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule